// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Coalescer

This block is the register front end of one direction of a scatter-gather DMA. Software reaches it through a simple 32-bit word read/write port. Through that port it sets a control word, watches a status word, and loads two descriptor pointers. The first is the current-descriptor pointer, which tells the walker where to begin. The second is the tail pointer, which tells the walker where to stop. The block drives the run, burst-mode, cyclic-mode and soft-reset signals towards the descriptor walker. It sees that walker only through four inputs: a completion pulse, an error vector, a busy level and a ring-empty level.

Completion interrupts are coalesced in two ways. A down-counter raises the completion cause after a programmable number of completions. An inactivity timer, counted in units of 125 clock cycles, raises a separate delay cause when completions stop arriving before the count is reached. A third cause covers errors. Each cause is latched in the status word and is cleared by writing 1 to it. One interrupt line is the OR of the latched causes, each gated by its own enable.

The status word also shows two channel states. The halted state means run is off and the walker has drained its work; in this state a tail write is dropped. The idle state means the ring ran dry while the channel was running; a tail write then restarts the walker.

Top module: `dmac_chan_ctrl`

## Requirements
- R1: After reset the control word reads 0x0001_0000 and the status word reads 0x0001_0009 (halted, scatter-gather present, count 1). Both pointers read 0 and irq is 0.
- R2: Control bits are: run at bit 0, soft reset at bit 2, fixed-address burst at bit 3, cyclic mode at bit 4, and the completion, delay and error interrupt enables at bits 12, 13 and 14. The threshold is at bits 23:16 and the delay timeout at bits 31:24. All other bits read 0. run_en, fixed_burst and cyclic_en follow bits 0, 3 and 4.
- R3: Status bit 0 (halted) clears on the second clock edge after run is written 1. After run is written 0, the bit sets on the first edge at which walk_busy is low.
- R4: Pointers sit at offsets 0x08/0x0C (current, low/high) and 0x10/0x14 (tail, low/high), and their low 6 bits read 0. A tail write that arrives while not halted updates tail_ptr; a write to 0x10 also pulses tail_kick for one cycle after the write edge. While halted, tail writes change nothing. The current pointer can be written only while halted.
- R5: Status bit 1 (idle) sets when the channel is running, not halted, ring_empty is high and walk_busy is low. It clears on an accepted write to 0x10 or when run is 0, and it is never set together with halted.
- R6: Each xfer_done pulse decrements the count shown in status bits 23:16. The pulse that finds the count at 1 sets the completion flag (status bit 12) and reloads the count with the threshold.
- R7: A threshold of 0 behaves as 1. Any control write reloads the count from the newly written threshold.
- R8: A completion that does not set the completion flag starts the delay timer. After timeout × 125 cycles with no further completion, the delay flag (status bit 13) sets and the count reloads. Status bits 31:24 show the elapsed whole units.
- R9: Each new completion restarts the delay timer from zero. A timeout of 0 never sets the delay flag.
- R10: xfer_err bits [2:0] (internal, slave, decode during data moves) latch sticky into status bits 4, 5 and 6. Bits [5:3] (the same three during descriptor fetch) latch into bits 8, 9 and 10. Any error bit sets the error flag at status bit 14.
- R11: Writing the status word clears flag bits 12, 13 and 14 where the data has 1s and leaves the other bits alone. A cause that arrives in the same cycle as its clear wins.
- R12: irq is high exactly when a latched flag has its enable bit set. Enabling a flag that is already set raises irq at once.
- R13: Writing control bit 2 starts a soft reset. soft_rst and control bit 2 read 1 for 8 cycles, and register writes are ignored during that time. After it, every register is back at its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the register; must be word aligned for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| xfer_done | input | 1 | One-cycle completion pulse from the walker |
| xfer_err | input | 6 | Error pulses: data int/slave/decode [2:0], descriptor int/slave/decode [5:3] |
| walk_busy | input | 1 | Walker has a transfer in flight |
| ring_empty | input | 1 | Walker reached the tail pointer |
| run_en | output | 1 | Run command to the walker |
| fixed_burst | output | 1 | Fixed-address burst mode |
| cyclic_en | output | 1 | Cyclic descriptor mode |
| soft_rst | output | 1 | Soft reset for both directions |
| tail_kick | output | 1 | One-cycle restart pulse after an accepted tail write |
| cur_ptr | output | 64 | Current-descriptor pointer |
| tail_ptr | output | 64 | Tail-descriptor pointer |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a delay-timer expiry that falls at exactly the right moment. It requires a completion that leaves the count above 1, followed by a stretch of 125 × timeout quiet cycles. The bench sets a threshold of 3 and a timeout of 2 and sends one pulse. It samples the status one cycle before and one cycle at the 250-cycle mark. It then repeats the test with a second pulse in mid-window to show the restart. Randomised pulse trains with random thresholds check the count against a bench model. Directed cases cover a threshold of 0, a clear that coincides with a set, and tail writes refused while halted.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
   // word index of each register (byte offset >> 2)
   localparam logic [3:0] W_CTRL    = 4'h0;
   localparam logic [3:0] W_STAT    = 4'h1;
   localparam logic [3:0] W_CUR_LO  = 4'h2;
   localparam logic [3:0] W_CUR_HI  = 4'h3;
   localparam logic [3:0] W_TAIL_LO = 4'h4;
   localparam logic [3:0] W_TAIL_HI = 4'h5;

   localparam int FLD_W  = 8;
   localparam int ERR_W  = 6;
   localparam int B_SRST = 2;
   localparam int B_IOC  = 12;
   localparam int B_DLY  = 13;
   localparam int B_ERR  = 14;

   typedef struct packed {
      logic [FLD_W-1:0] dly;
      logic [FLD_W-1:0] thr;
      logic             err_en;
      logic             dly_en;
      logic             ioc_en;
      logic             cyc;
      logic             fix;
      logic             run;
   } ctrl_t;

   localparam ctrl_t CTRL_RST = '{dly: 8'd0, thr: 8'd1, err_en: 1'b0, dly_en: 1'b0,
                                  ioc_en: 1'b0, cyc: 1'b0, fix: 1'b0, run: 1'b0};
endpackage

// File: rtl/dmac_srst_seq.sv
`timescale 1ns/1ps
module dmac_srst_seq #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("dmac_srst_seq: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (start && cnt_q == '0)   cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)            cnt_q <= cnt_q - CW'(1);
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/dmac_coalesce.sv
`timescale 1ns/1ps
module dmac_coalesce #(
   parameter int UNIT = 125,
   parameter int W    = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_thr,
   input  logic [W-1:0] thr,
   input  logic [W-1:0] delay,
   input  logic         done,
   output logic [W-1:0] thr_cnt,
   output logic [W-1:0] dly_cnt,
   output logic         ioc_hit,
   output logic         dly_hit
);
   if (UNIT < 1) begin : g_bad_unit
      $error("dmac_coalesce: UNIT must be at least 1");
   end

   logic [W-1:0] thr_eff, load_eff;
   logic         pend_q, run_tmr, tick, quiet;

   assign thr_eff  = (thr == '0)      ? W'(1) : thr;
   assign load_eff = (load_thr == '0) ? W'(1) : load_thr;
   assign quiet    = !clr && !load;
   assign run_tmr  = pend_q && (delay != '0);
   assign ioc_hit  = quiet && done && (thr_cnt <= W'(1));
   assign dly_hit  = quiet && !done && tick && (dly_cnt == delay - W'(1));

   // unit prescaler: present only when a unit spans more than one cycle
   if (UNIT > 1) begin : g_pre
      localparam int PW = $clog2(UNIT);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  pre_q <= '0;
         else if (!quiet || done || !run_tmr)         pre_q <= '0;
         else if (pre_q == PW'(UNIT - 1))             pre_q <= '0;
         else                                         pre_q <= pre_q + PW'(1);
      end
      assign tick = run_tmr && (pre_q == PW'(UNIT - 1));
   end else begin : g_nopre
      assign tick = run_tmr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_cnt <= W'(1);
         dly_cnt <= '0;
         pend_q  <= 1'b0;
      end else if (clr) begin
         thr_cnt <= W'(1);
         dly_cnt <= '0;
         pend_q  <= 1'b0;
      end else if (load) begin
         thr_cnt <= load_eff;
         dly_cnt <= '0;
         pend_q  <= 1'b0;
      end else if (done) begin
         thr_cnt <= ioc_hit ? thr_eff : thr_cnt - W'(1);
         dly_cnt <= '0;
         pend_q  <= !ioc_hit;
      end else if (dly_hit) begin
         thr_cnt <= thr_eff;
         dly_cnt <= '0;
         pend_q  <= 1'b0;
      end else if (tick) begin
         dly_cnt <= dly_cnt + W'(1);
      end
   end
endmodule

// File: rtl/dmac_chan_ctrl.sv
`timescale 1ns/1ps
module dmac_chan_ctrl
   import dmac_pkg::*;
#(
   parameter int DLY_UNIT   = 125,
   parameter int RST_CYCLES = 8,
   parameter int PTR_ALIGN  = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [5:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        xfer_done,
   input  logic [5:0]  xfer_err,
   input  logic        walk_busy,
   input  logic        ring_empty,
   output logic        run_en,
   output logic        fixed_burst,
   output logic        cyclic_en,
   output logic        soft_rst,
   output logic        tail_kick,
   output logic [63:0] cur_ptr,
   output logic [63:0] tail_ptr,
   output logic        irq
);
   localparam logic [31:0] LO_MASK = ~((32'd1 << PTR_ALIGN) - 32'd1);

   if (PTR_ALIGN < 0 || PTR_ALIGN > 31) begin : g_bad_align
      $error("dmac_chan_ctrl: PTR_ALIGN out of range");
   end

   ctrl_t             ctrl_q;
   logic              halted_q, idle_q;
   logic              ioc_f, dly_f, err_f;
   logic [ERR_W-1:0]  errs_q;
   logic [31:0]       cur_lo, cur_hi, tail_lo, tail_hi;
   logic              busy, wr_ok, tail_acc;
   logic              sel_ctrl, sel_stat, sel_cur_lo, sel_cur_hi, sel_tail_lo, sel_tail_hi;
   logic [FLD_W-1:0]  thr_cnt, dly_cnt;
   logic              ioc_hit, dly_hit, cfg_load;

   assign wr_ok       = reg_we && !busy && (reg_addr[1:0] == 2'b00);
   assign sel_ctrl    = wr_ok && reg_addr[5:2] == W_CTRL;
   assign sel_stat    = wr_ok && reg_addr[5:2] == W_STAT;
   assign sel_cur_lo  = wr_ok && reg_addr[5:2] == W_CUR_LO;
   assign sel_cur_hi  = wr_ok && reg_addr[5:2] == W_CUR_HI;
   assign sel_tail_lo = wr_ok && reg_addr[5:2] == W_TAIL_LO;
   assign sel_tail_hi = wr_ok && reg_addr[5:2] == W_TAIL_HI;
   assign cfg_load    = sel_ctrl && !reg_wdata[B_SRST];
   assign tail_acc    = sel_tail_lo && !halted_q;

   dmac_srst_seq #(.CYCLES(RST_CYCLES)) u_srst (
      .clk(clk), .rst_n(rst_n), .start(sel_ctrl && reg_wdata[B_SRST]), .busy(busy));

   dmac_coalesce #(.UNIT(DLY_UNIT), .W(FLD_W)) u_coal (
      .clk(clk), .rst_n(rst_n), .clr(busy), .load(cfg_load),
      .load_thr(reg_wdata[23:16]), .thr(ctrl_q.thr), .delay(ctrl_q.dly),
      .done(xfer_done), .thr_cnt(thr_cnt), .dly_cnt(dly_cnt),
      .ioc_hit(ioc_hit), .dly_hit(dly_hit));

   // control word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctrl_q <= CTRL_RST;
      else if (busy)     ctrl_q <= CTRL_RST;
      else if (cfg_load) ctrl_q <= '{dly: reg_wdata[31:24], thr: reg_wdata[23:16],
                                     err_en: reg_wdata[14], dly_en: reg_wdata[13],
                                     ioc_en: reg_wdata[12], cyc: reg_wdata[4],
                                     fix: reg_wdata[3], run: reg_wdata[0]};
   end

   // channel state: halted and idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q <= 1'b1;
         idle_q   <= 1'b0;
      end else if (busy) begin
         halted_q <= 1'b1;
         idle_q   <= 1'b0;
      end else begin
         if (ctrl_q.run)      halted_q <= 1'b0;
         else if (!walk_busy) halted_q <= 1'b1;
         if (!ctrl_q.run || tail_acc)                       idle_q <= 1'b0;
         else if (!halted_q && ring_empty && !walk_busy)    idle_q <= 1'b1;
      end
   end

   // latched causes (set beats write-one-to-clear) and sticky error kinds
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ioc_f  <= 1'b0;
         dly_f  <= 1'b0;
         err_f  <= 1'b0;
         errs_q <= '0;
      end else if (busy) begin
         ioc_f  <= 1'b0;
         dly_f  <= 1'b0;
         err_f  <= 1'b0;
         errs_q <= '0;
      end else begin
         ioc_f  <= ioc_hit     | (ioc_f & !(sel_stat && reg_wdata[B_IOC]));
         dly_f  <= dly_hit     | (dly_f & !(sel_stat && reg_wdata[B_DLY]));
         err_f  <= (|xfer_err) | (err_f & !(sel_stat && reg_wdata[B_ERR]));
         errs_q <= errs_q | xfer_err;
      end
   end

   // descriptor pointers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_lo <= '0; cur_hi <= '0; tail_lo <= '0; tail_hi <= '0;
         tail_kick <= 1'b0;
      end else if (busy) begin
         cur_lo <= '0; cur_hi <= '0; tail_lo <= '0; tail_hi <= '0;
         tail_kick <= 1'b0;
      end else begin
         if (sel_cur_lo && halted_q)      cur_lo  <= reg_wdata & LO_MASK;
         if (sel_cur_hi && halted_q)      cur_hi  <= reg_wdata;
         if (tail_acc)                    tail_lo <= reg_wdata & LO_MASK;
         if (sel_tail_hi && !halted_q)    tail_hi <= reg_wdata;
         tail_kick <= tail_acc;
      end
   end

   always_comb begin
      unique case (reg_addr[5:2])
         W_CTRL:    reg_rdata = {ctrl_q.dly, ctrl_q.thr, 1'b0, ctrl_q.err_en, ctrl_q.dly_en,
                                 ctrl_q.ioc_en, 7'd0, ctrl_q.cyc, ctrl_q.fix, busy, 1'b0,
                                 ctrl_q.run};
         W_STAT:    reg_rdata = {dly_cnt, thr_cnt, 1'b0, err_f, dly_f, ioc_f, 1'b0,
                                 errs_q[5:3], 1'b0, errs_q[2:0], 1'b1, 1'b0, idle_q, halted_q};
         W_CUR_LO:  reg_rdata = cur_lo;
         W_CUR_HI:  reg_rdata = cur_hi;
         W_TAIL_LO: reg_rdata = tail_lo;
         W_TAIL_HI: reg_rdata = tail_hi;
         default:   reg_rdata = '0;
      endcase
   end

   assign run_en      = ctrl_q.run;
   assign fixed_burst = ctrl_q.fix;
   assign cyclic_en   = ctrl_q.cyc;
   assign soft_rst    = busy;
   assign cur_ptr     = {cur_hi, cur_lo};
   assign tail_ptr    = {tail_hi, tail_lo};
   assign irq         = (ioc_f & ctrl_q.ioc_en) | (dly_f & ctrl_q.dly_en) | (err_f & ctrl_q.err_en);
endmodule

// File: rtl/dmac_chan_ctrl_chk.sv
`timescale 1ns/1ps
module dmac_chan_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_we,
   input logic [5:0]  reg_addr,
   input logic        run_en,
   input logic        soft_rst,
   input logic        tail_kick,
   input logic [63:0] tail_ptr,
   input logic        halted,
   input logic        idle,
   input logic [7:0]  thr_cnt,
   input logic        dly_flag,
   input logic [7:0]  dly_field
);
   assert_halt_blocks_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && reg_we && !soft_rst && reg_addr == 6'h10) |=> (!tail_kick && $stable(tail_ptr)));

   assert_srst_stops_run_R13: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !run_en);

   assert_count_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      thr_cnt != 8'd0);

   assert_running_not_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && $past(run_en)) |-> !halted);

   assert_idle_halt_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(idle && halted));

   assert_dly_needs_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dly_flag) |-> dly_field != 8'd0);
endmodule

bind dmac_chan_ctrl dmac_chan_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .run_en(run_en),
   .soft_rst(soft_rst), .tail_kick(tail_kick), .tail_ptr(tail_ptr), .halted(halted_q),
   .idle(idle_q), .thr_cnt(thr_cnt), .dly_flag(dly_f), .dly_field(ctrl_q.dly));

// File: tb/dmac_chan_ctrl_test.sv
`timescale 1ns/1ps
module dmac_chan_ctrl_test;
   localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h04, A_CUR = 6'h08,
                          A_TAIL = 6'h10, A_TAILH = 6'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        xfer_done = 1'b0;
   logic [5:0]  xfer_err = '0;
   logic        walk_busy = 1'b0;
   logic        ring_empty = 1'b0;
   logic        run_en, fixed_burst, cyclic_en, soft_rst, tail_kick, irq;
   logic [63:0] cur_ptr, tail_ptr;
   int          errors = 0;
   int          checks = 0;
   logic [31:0] r;

   always #2.5 clk = ~clk;

   dmac_chan_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .xfer_done(xfer_done), .xfer_err(xfer_err),
      .walk_busy(walk_busy), .ring_empty(ring_empty), .run_en(run_en),
      .fixed_burst(fixed_burst), .cyclic_en(cyclic_en), .soft_rst(soft_rst),
      .tail_kick(tail_kick), .cur_ptr(cur_ptr), .tail_ptr(tail_ptr), .irq(irq));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic pulse();
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] model_next(input logic [7:0] cnt, input logic [7:0] thr,
                                             output logic hit);
      hit = (cnt <= 8'd1);
      return hit ? thr : cnt - 8'd1;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] mcnt, mthr;
      logic       mflag, hit;
      int         n;
      void'($urandom(32'd4242));
      wait_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, r);  chk("R1 ctrl", r, 32'h0001_0000);
      rd(A_STAT, r);  chk("R1 status", r, 32'h0001_0009);
      chk("R1 pointers", {cur_ptr | tail_ptr}, 64'h0);
      chk("R1 irq", irq, 1'b0);

      // R4 current pointer writable while halted, low bits dropped
      wr(A_CUR, 32'h1234_5678);
      rd(A_CUR, r);   chk("R4 cur write halted", r, 32'h1234_5640);

      // R2 field map
      wr(A_CTRL, 32'hFFFF_FFFB);
      rd(A_CTRL, r);  chk("R2 ctrl readback", r, 32'hFFFF_7019);
      chk("R2 outputs", {run_en, fixed_burst, cyclic_en}, 3'b111);
      // R3 halted clears on second edge after run write
      rd(A_STAT, r);  chk("R3 halted one edge after run", r[0], 1'b1);
      wait_cyc(1);
      rd(A_STAT, r);  chk("R3 halted clears", r[0], 1'b0);

      // R4 current pointer locked while running
      wr(A_CUR, 32'hFFFF_FFC0);
      rd(A_CUR, r);   chk("R4 cur locked running", r, 32'h1234_5640);

      // R6 threshold counting
      wr(A_CTRL, 32'h0003_7001);
      rd(A_STAT, r);  chk("R7 reload on ctrl write", r[23:16], 8'd3);
      pulse(); pulse();
      rd(A_STAT, r);  chk("R6 count after two", r[23:16], 8'd1);
      chk("R6 no flag yet", {r[12], irq}, 2'b00);
      pulse();
      rd(A_STAT, r);  chk("R6 flag on third", r[12], 1'b1);
      chk("R6 count reloaded", r[23:16], 8'd3);
      chk("R12 irq on ioc", irq, 1'b1);

      // R11 write-one-to-clear
      wr(A_STAT, 32'h0000_2000);
      rd(A_STAT, r);  chk("R11 other bit kept", r[12], 1'b1);
      wr(A_STAT, 32'h0000_1000);
      rd(A_STAT, r);  chk("R11 cleared", r[12], 1'b0);
      chk("R12 irq drops", irq, 1'b0);

      // R7 threshold zero acts as one
      wr(A_CTRL, 32'h0000_7001);
      rd(A_STAT, r);  chk("R7 zero threshold count", r[23:16], 8'd1);
      pulse();
      rd(A_STAT, r);  chk("R7 single pulse fires", r[12], 1'b1);
      wr(A_STAT, 32'h0000_1000);

      // R8 delay timer, timeout 2 units
      wr(A_CTRL, 32'h0203_7001);
      pulse();
      wait_cyc(249);
      rd(A_STAT, r);  chk("R8 not yet expired", r[13], 1'b0);
      chk("R8 unit count", r[31:24], 8'd1);
      wait_cyc(1);
      rd(A_STAT, r);  chk("R8 expired", r[13], 1'b1);
      chk("R8 count reload", r[23:16], 8'd3);
      chk("R12 irq on delay", irq, 1'b1);
      wr(A_STAT, 32'h0000_2000);

      // R9 restart on new completion
      pulse();
      wait_cyc(200);
      pulse();
      wait_cyc(249);
      rd(A_STAT, r);  chk("R9 restarted timer", r[13], 1'b0);
      wait_cyc(1);
      rd(A_STAT, r);  chk("R9 expiry after restart", r[13], 1'b1);
      wr(A_STAT, 32'h0000_2000);

      // R9 timeout zero never fires
      wr(A_CTRL, 32'h0003_7001);
      pulse();
      wait_cyc(400);
      rd(A_STAT, r);  chk("R9 zero timeout", r[13], 1'b0);

      // R12 enable gating
      wr(A_CTRL, 32'h0001_6001);
      pulse();
      rd(A_STAT, r);  chk("R12 flag set", r[12], 1'b1);
      chk("R12 masked irq", irq, 1'b0);
      wr(A_CTRL, 32'h0001_7001);
      chk("R12 late enable", irq, 1'b1);
      wr(A_STAT, 32'h0000_1000);

      // R10 errors
      xfer_err = 6'b100000; @(negedge clk); xfer_err = '0;
      rd(A_STAT, r);  chk("R10 desc decode", {r[14], r[10]}, 2'b11);
      chk("R10 irq", irq, 1'b1);
      xfer_err = 6'b000010; @(negedge clk); xfer_err = '0;
      rd(A_STAT, r);  chk("R10 data slave", r[5], 1'b1);
      wr(A_STAT, 32'h0000_4000);
      rd(A_STAT, r);  chk("R10 kinds sticky", {r[14], r[10], r[5]}, 3'b011);
      // R11 set wins over clear
      xfer_err = 6'b000001;
      wr(A_STAT, 32'h0000_4000);
      xfer_err = '0;
      rd(A_STAT, r);  chk("R11 set wins", r[14], 1'b1);
      wr(A_STAT, 32'h0000_4000);

      // R6 random pulse trains against model
      mflag = 1'b0; mthr = 8'd1; mcnt = 8'd1;
      for (int i = 0; i < 48; i++) begin
         if (i % 12 == 0) begin
            mthr = 8'($urandom_range(1, 6));
            wr(A_CTRL, {8'd0, mthr, 16'h1001});
            mcnt = mthr;
         end
         wait_cyc($urandom_range(0, 3));
         pulse();
         mcnt = model_next(mcnt, mthr, hit);
         mflag = mflag | hit;
         rd(A_STAT, r);
         chk("R6 random count", r[23:16], mcnt);
         chk("R6 random flag", r[12], mflag);
         chk("R12 random irq", irq, mflag);
         if (mflag) begin
            wr(A_STAT, 32'h0000_1000);
            mflag = 1'b0;
         end
      end

      // R5 idle and tail restart
      ring_empty = 1'b1;
      @(negedge clk);
      rd(A_STAT, r);  chk("R5 idle set", r[1:0], 2'b10);
      ring_empty = 1'b0;
      wr(A_TAIL, 32'h0000_12FF);
      chk("R4 tail kick", tail_kick, 1'b1);
      chk("R4 tail low", tail_ptr, 64'h12C0);
      rd(A_STAT, r);  chk("R5 idle cleared", r[1], 1'b0);
      wr(A_TAILH, 32'h0000_0005);
      chk("R4 tail high no kick", {63'(tail_ptr), tail_kick}, {63'(64'h5_0000_12C0), 1'b0});

      // R3 halt waits for in-flight work
      walk_busy = 1'b1;
      wr(A_CTRL, 32'h0003_7000);
      @(negedge clk);
      rd(A_STAT, r);  chk("R3 busy holds off halt", r[0], 1'b0);
      walk_busy = 1'b0;
      @(negedge clk);
      rd(A_STAT, r);  chk("R3 halted after drain", r[0], 1'b1);

      // R4 tail write ignored while halted
      wr(A_TAIL, 32'h0000_ABC0);
      chk("R4 halted tail ignored", tail_ptr, 64'h5_0000_12C0);
      chk("R4 halted no kick", tail_kick, 1'b0);

      // R13 soft reset
      wr(A_CTRL, 32'h0000_0004);
      rd(A_CTRL, r);  chk("R13 reset bit reads 1", {r[2], soft_rst}, 2'b11);
      n = 1;
      wr(A_CTRL, 32'h0000_0001);
      if (soft_rst) n++;
      while (soft_rst && n < 50) begin
         @(negedge clk);
         if (soft_rst) n++;
      end
      chk("R13 reset length", n, 8);
      rd(A_CTRL, r);  chk("R13 ctrl restored", r, 32'h0001_0000);
      rd(A_STAT, r);  chk("R13 status restored", r, 32'h0001_0009);
      chk("R13 pointers cleared", {cur_ptr | tail_ptr}, 64'h0);
      chk("R13 run off", run_en, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule